// File: doc/BRIEF.md
# Quadrature Chroma Modulator with Subcarrier Synthesizer

This block forms the digital chrominance sample of a composite video encoder. A 32-bit phase accumulator, stepped by a programmable frequency word once for every accepted pixel beat, synthesizes the colour subcarrier. The accumulator value plus a phase offset addresses a quarter-wave sine table. A second lookup a quarter turn ahead gives the cosine. The two colour-difference samples of each beat are modulated onto sine and cosine and summed.

Each input beat carries two window flags. While the burst flag is set, the output is a programmable burst amplitude times the sine, and the phase uses the burst offset. While only the active flag is set, the phase uses the active-video offset. That offset acts as a hue control, and the burst offset corrects external phase error independently. With neither flag set, the output is zero. A genlock load pulse forces the accumulator to a supplied phase, which locks the oscillator to incoming video.

Pixel beats enter on a valid/ready stream and leave on a valid/ready stream after a two-stage pipeline. The whole pipeline advances only when the output register is empty or is being taken, so `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A beat is transferred on a clock edge where valid and ready are both high. The output holds its data while it is stalled. Register inputs (frequency, offsets, amplitude) are plain levels.

Top module: `chroma_mod`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and the phase accumulator is 0.
- R2: On each accepted input beat, the accumulator advances by `freq_word` modulo 2^32. With no accepted beat and no load, it holds.
- R3: When `lock_load` is high at a clock edge, the accumulator takes `lock_phase` at that edge, overriding any advance. A beat accepted at the same edge still uses the old accumulator value.
- R4: The table address is bits [31:22] of (accumulator + offset). The offset is `burst_offset` when the beat's burst flag is set and `active_offset` otherwise. The sine at address a is round(2047·sin(2π(a+0.5)/1024)), with halves rounded away from zero. The cosine is the sine at address a+256 mod 1024.
- R5: For a beat with the active flag set and the burst flag clear, `out_chroma` = floor((U·sin + V·cos)/2048). U and V are signed 10-bit values.
- R6: For a beat with the burst flag set, whatever the active flag, `out_chroma` = floor(A·sin/2048). A is the unsigned 9-bit `burst_amp`.
- R7: For a beat with neither flag set, `out_chroma` is 0.
- R8: A beat accepted at edge k is presented with `out_valid` after edge k+2 when the output is not stalled. Beats leave in the order they entered.
- R9: `in_ready` = !out_valid || out_ready. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_chroma` hold and no beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_word | input | 32 | Subcarrier phase step per accepted beat |
| burst_offset | input | 32 | Phase offset during burst window |
| active_offset | input | 32 | Phase offset during active video (hue) |
| burst_amp | input | 9 | Unsigned burst amplitude |
| lock_load | input | 1 | Genlock load pulse |
| lock_phase | input | 32 | Phase loaded by `lock_load` |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat ready |
| in_u | input | 10 | Signed colour-difference sample on sine |
| in_v | input | 10 | Signed colour-difference sample on cosine |
| in_burst | input | 1 | Beat lies in the burst window |
| in_active | input | 1 | Beat lies in active video |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Output sample taken |
| out_chroma | output | 12 | Signed chroma sample |

## Verification
If the accumulator steps wrongly or is loaded wrongly, the phase of every later output sample is shifted. The error appears on the first beat out, two cycles after the faulty step, and on every beat after it. A wrong table entry or a wrong quadrant mirror shows only at the phases that use it, so sweeps step the phase one table entry per beat over the full circle for sine, cosine and burst. A pipeline or handshake fault shows as a sample lost, repeated or reordered against the bench's queue, or as data that changes while the output is stalled.

// File: rtl/chroma_pkg.sv
package chroma_pkg;
  typedef enum logic [1:0] {
    WIN_BLANK  = 2'd0,
    WIN_ACTIVE = 2'd1,
    WIN_BURST  = 2'd2
  } win_e;
endpackage

// File: rtl/chroma_phase_acc.sv
module chroma_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [ACC_W-1:0] freq,
  input  logic             load,
  input  logic [ACC_W-1:0] load_val,
  output logic [ACC_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (!rst_n)    acc <= '0;
    else if (load) acc <= load_val;
    else if (step) acc <= acc + freq;
  end
endmodule

// File: rtl/chroma_sine_lut.sv
module chroma_sine_lut #(
  parameter int AW = 10,
  parameter int SW = 12
) (
  input  logic [AW-1:0]        addr,
  output logic signed [SW-1:0] val
);
  localparam int  QUARTER = 1 << (AW - 2);
  localparam real AMP     = real'((1 << (SW - 1)) - 1);
  localparam real TWO_PI  = 6.283185307179586;

  logic [SW-2:0] qtab [QUARTER];

  for (genvar i = 0; i < QUARTER; i++) begin : g_entry
    localparam real ANG = TWO_PI * (real'(i) + 0.5) / real'(1 << AW);
    localparam int  MAG = $rtoi(AMP * $sin(ANG) + 0.5);
    assign qtab[i] = MAG[SW-2:0];
  end

  logic [AW-3:0] idx;
  logic [SW-2:0] mag;

  always_comb begin
    idx = addr[AW-2] ? ~addr[AW-3:0] : addr[AW-3:0];
    mag = qtab[idx];
    val = addr[AW-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end
endmodule

// File: rtl/chroma_mac.sv
module chroma_mac #(
  parameter int CW = 10,
  parameter int SW = 12,
  localparam int OW = CW + 2
) (
  input  logic signed [CW-1:0] op_a,
  input  logic signed [CW-1:0] op_b,
  input  logic signed [SW-1:0] sin_v,
  input  logic signed [SW-1:0] cos_v,
  output logic signed [OW-1:0] y
);
  localparam int SUMW = CW + SW + 1;

  logic signed [SUMW-1:0] pa, pb, sum;
  logic                   unused_low;

  always_comb begin
    pa  = SUMW'(op_a) * SUMW'(sin_v);
    pb  = SUMW'(op_b) * SUMW'(cos_v);
    sum = pa + pb;
    y   = sum[SUMW-1:SW-1];
  end

  assign unused_low = ^sum[SW-2:0];
endmodule

// File: rtl/chroma_mod.sv
module chroma_mod
  import chroma_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int AW    = 10,
  parameter int SW    = 12,
  parameter int CW    = 10,
  localparam int OW   = CW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] freq_word,
  input  logic [ACC_W-1:0] burst_offset,
  input  logic [ACC_W-1:0] active_offset,
  input  logic [CW-2:0]    burst_amp,
  input  logic             lock_load,
  input  logic [ACC_W-1:0] lock_phase,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CW-1:0]    in_u,
  input  logic [CW-1:0]    in_v,
  input  logic             in_burst,
  input  logic             in_active,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OW-1:0]    out_chroma
);
  localparam logic [AW-1:0] QTURN = AW'(1 << (AW - 2));

  logic             adv;
  logic             accept;
  logic [ACC_W-1:0] phase_acc;
  logic [ACC_W-1:0] phase_sum;
  logic [AW-1:0]    addr_s, addr_c;
  logic signed [SW-1:0] sin_w, cos_w;
  logic signed [CW-1:0] opa_w, opb_w;
  win_e             win;
  logic             unused_phase;

  // whole pipeline moves when the output slot is free or being taken
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign accept   = in_valid && adv;

  chroma_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .step(accept), .freq(freq_word),
    .load(lock_load), .load_val(lock_phase), .acc(phase_acc)
  );

  always_comb begin
    if (in_burst)       win = WIN_BURST;
    else if (in_active) win = WIN_ACTIVE;
    else                win = WIN_BLANK;
    phase_sum = phase_acc + ((win == WIN_BURST) ? burst_offset : active_offset);
    addr_s    = phase_sum[ACC_W-1 -: AW];
    addr_c    = addr_s + QTURN;
    case (win)
      WIN_BURST:  begin opa_w = $signed({1'b0, burst_amp}); opb_w = '0; end
      WIN_ACTIVE: begin opa_w = $signed(in_u);              opb_w = $signed(in_v); end
      default:    begin opa_w = '0;                         opb_w = '0; end
    endcase
  end

  assign unused_phase = ^phase_sum[ACC_W-AW-1:0];

  chroma_sine_lut #(.AW(AW), .SW(SW)) u_sin (.addr(addr_s), .val(sin_w));
  chroma_sine_lut #(.AW(AW), .SW(SW)) u_cos (.addr(addr_c), .val(cos_w));

  // stage 1: operands and trig values
  logic                 s1_valid;
  logic signed [CW-1:0] s1_a, s1_b;
  logic signed [SW-1:0] s1_sin, s1_cos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_a     <= '0;
      s1_b     <= '0;
      s1_sin   <= '0;
      s1_cos   <= '0;
    end else if (adv) begin
      s1_valid <= in_valid;
      s1_a     <= opa_w;
      s1_b     <= opb_w;
      s1_sin   <= sin_w;
      s1_cos   <= cos_w;
    end
  end

  // stage 2: multiply-accumulate into the output register
  logic signed [OW-1:0] mac_y;

  chroma_mac #(.CW(CW), .SW(SW)) u_mac (
    .op_a(s1_a), .op_b(s1_b), .sin_v(s1_sin), .cos_v(s1_cos), .y(mac_y)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_chroma <= '0;
    end else if (adv) begin
      out_valid  <= s1_valid;
      out_chroma <= mac_y;
    end
  end
endmodule

// File: rtl/chroma_mod_chk.sv
module chroma_mod_chk #(
  parameter int ACC_W = 32,
  parameter int OW    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OW-1:0]    out_chroma,
  input logic             lock_load,
  input logic [ACC_W-1:0] lock_phase,
  input logic [ACC_W-1:0] freq_word,
  input logic [ACC_W-1:0] phase_acc
);
  // R2
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_load && in_valid && in_ready) |=> phase_acc == $past(phase_acc) + $past(freq_word));
  // R2
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_load && !(in_valid && in_ready)) |=> $stable(phase_acc));
  // R3
  lock_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_load |=> phase_acc == $past(lock_phase));
  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 out_valid);
  // R8
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2));
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_chroma));
  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind chroma_mod chroma_mod_chk #(.ACC_W(ACC_W), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_chroma(out_chroma),
  .lock_load(lock_load), .lock_phase(lock_phase), .freq_word(freq_word),
  .phase_acc(phase_acc)
);

// File: tb/chroma_mod_tb.sv
module chroma_mod_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] freq_word = '0, burst_offset = '0, active_offset = '0, lock_phase = '0;
  logic [8:0]  burst_amp = '0;
  logic        lock_load = 1'b0, in_valid = 1'b0, in_burst = 1'b0, in_active = 1'b0;
  logic        out_ready = 1'b1;
  logic [9:0]  in_u = '0, in_v = '0;
  logic        in_ready, out_valid;
  logic [11:0] out_chroma;

  always #4 clk = ~clk;

  chroma_mod u_dut (
    .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .burst_offset(burst_offset),
    .active_offset(active_offset), .burst_amp(burst_amp), .lock_load(lock_load),
    .lock_phase(lock_phase), .in_valid(in_valid), .in_ready(in_ready), .in_u(in_u),
    .in_v(in_v), .in_burst(in_burst), .in_active(in_active), .out_valid(out_valid),
    .out_ready(out_ready), .out_chroma(out_chroma)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] m_acc = '0;
  int expq[$];
  string tagq[$];
  string cur_tag = "R5";

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sinref(int a);
    real s;
    s = 2047.0 * $sin(6.283185307179586 * (real'(a % 1024) + 0.5) / 1024.0);
    if (s >= 0.0) return $rtoi(s + 0.5);
    return -$rtoi(-s + 0.5);
  endfunction

  function automatic int expect_val(logic [31:0] acc);
    logic [31:0] p;
    int a, s, c, sum;
    p = acc + (in_burst ? burst_offset : active_offset);
    a = int'(p[31:22]);
    s = sinref(a);
    c = sinref(a + 256);
    if (in_burst)       sum = int'(burst_amp) * s;
    else if (in_active) sum = int'($signed(in_u)) * s + int'($signed(in_v)) * c;
    else                sum = 0;
    return sum >>> 11;
  endfunction

  task automatic step(output bit acc);
    int e;
    string t;
    #1;
    acc = in_valid && in_ready;
    chk(in_ready == (!out_valid || out_ready), "R9", int'(in_ready), int'(!out_valid || out_ready));
    if (out_valid && out_ready) begin
      if (expq.size() == 0) chk(0, "R8", int'($signed(out_chroma)), -99999);
      else begin
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(int'($signed(out_chroma)) == e, t, int'($signed(out_chroma)), e);
      end
    end
    if (acc) begin
      expq.push_back(expect_val(m_acc));
      tagq.push_back(cur_tag);
    end
    if (lock_load) m_acc = lock_phase;
    else if (acc)  m_acc = m_acc + freq_word;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(int u, int v, bit b, bit a);
    bit acc;
    in_valid = 1'b1; in_u = 10'(u); in_v = 10'(v); in_burst = b; in_active = a;
    do step(acc); while (!acc);
  endtask

  task automatic drain();
    bit acc;
    in_valid = 1'b0; out_ready = 1'b1;
    for (int k = 0; k < 8; k++) step(acc);
    chk(expq.size() == 0, "R8", expq.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit acc;
    int held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);

    // R4 R5: sine sweep, one table step per beat, starting from reset phase 0 (R1, R2)
    freq_word = 32'h0040_0000;
    cur_tag = "R5";
    for (int k = 0; k < 1024; k++) send(500, 0, 0, 1);
    // cosine sweep
    cur_tag = "R4";
    for (int k = 0; k < 1024; k++) send(0, -300, 0, 1);
    // mixed U/V pattern
    cur_tag = "R5";
    for (int k = 0; k < 1024; k++) send((k * 37) % 1023 - 511, 511 - (k * 53) % 1023, 0, 1);
    drain();

    // R6: burst wins over active, burst offset used
    burst_amp = 9'd511; burst_offset = 32'h1234_5678; active_offset = 32'h8000_0000;
    cur_tag = "R6";
    for (int k = 0; k < 1024; k++) send(200, 200, 1, k[0]);
    drain();

    // R7: no window gives zero
    cur_tag = "R7";
    for (int k = 0; k < 16; k++) send(300, -200, 0, 0);

    // R4 hue: quarter-turn active offset
    active_offset = 32'h4000_0000;
    cur_tag = "R4";
    for (int k = 0; k < 16; k++) send(400, 100, 0, 1);
    drain();

    // R3: load while idle, then load during an accepted beat
    freq_word = 32'h0123_4567;
    lock_phase = 32'hABCD_0000; lock_load = 1'b1;
    step(acc);
    lock_load = 1'b0;
    cur_tag = "R3";
    for (int k = 0; k < 8; k++) send(350, -150, 0, 1);
    lock_phase = 32'h3000_0000; lock_load = 1'b1;
    send(350, -150, 0, 1);
    lock_load = 1'b0;
    for (int k = 0; k < 8; k++) send(350, -150, 0, 1);
    drain();

    // R8: exact latency from an empty pipeline
    cur_tag = "R8";
    in_valid = 1'b1; in_u = 10'd100; in_v = 10'd0; in_burst = 0; in_active = 1;
    step(acc);
    in_valid = 1'b0;
    #1 chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
    step(acc);
    #1 chk(out_valid == 1'b1, "R8", int'(out_valid), 1);
    drain();

    // R9: stall holds data and blocks input
    cur_tag = "R9";
    out_ready = 1'b0;
    in_valid = 1'b1; in_u = 10'd250; in_v = 10'd120; in_active = 1;
    step(acc); step(acc); step(acc);
    #1 held = int'($signed(out_chroma));
    chk(out_valid == 1'b1, "R9", int'(out_valid), 1);
    for (int k = 0; k < 4; k++) begin
      step(acc);
      chk(acc == 1'b0, "R9", int'(acc), 0);
      chk(int'($signed(out_chroma)) == held, "R9", int'($signed(out_chroma)), held);
    end
    drain();

    // R8 R9: random traffic with back-pressure, order preserved
    cur_tag = "R8";
    burst_offset = 32'h0F00_1234; active_offset = 32'h2222_0000; burst_amp = 9'd300;
    for (int k = 0; k < 3000; k++) begin
      in_valid  = 1'($urandom_range(0, 1));
      out_ready = ($urandom_range(0, 3) != 0);
      in_u = 10'($urandom); in_v = 10'($urandom);
      in_burst = ($urandom_range(0, 7) == 0); in_active = 1'($urandom_range(0, 1));
      step(acc);
    end
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule